// File: doc/BRIEF.md
# Comma-Aligned Serial Symbol Framer

This block sits after a bit-recovery stage. It turns a stream of single bits, each marked by a valid strobe, into aligned 10-bit line symbols. It starts in a hunting state and watches every accepted bit for a 7-bit comma run. Only the alignment control symbol contains this run, so it marks where a symbol begins.

When the first comma is found, the block fixes the symbol boundary at the comma's first bit and enters a locked state. From then on it free-runs in steps of 10 accepted bits. Each completed group is emitted as one symbol with a single-cycle valid pulse. While locked, every comma that turns up is checked against the established boundary. A comma off the boundary raises an error pulse. Four symbols in a row that hold such a comma drop the block back to hunting. An error reported by the bit-recovery stage, or reset, also returns it to hunting.

Top module: `comma_sync`

## Requirements
- R1: While rst_ni is low, and from that point asynchronously, all outputs are 0: comma_o, locked_o, align_err_o, sym_vld_o and sym_o.
- R2: A bit on bit_i is taken only in a cycle where bit_vld_i is 1 and rec_err_i is 0. A bit with bit_vld_i low does not shift, does not count toward a symbol and cannot complete a comma.
- R3: comma_o is a one-cycle pulse in the cycle after a taken bit, when that bit and the six taken bits before it read 0011111 or 1100000 in arrival order. The window must also be filled entirely with bits taken since the last reset or recovery error, so reset fill never counts.
- R4: In the hunting state (locked_o = 0), a comma moves the block to the locked state. locked_o is 1 in the same cycle that comma_o pulses.
- R5: While locked, sym_vld_o pulses once every 10 taken bits, counted from the first bit of the locking comma. sym_o bit 0 holds the earliest-arriving bit of the group and bit 9 the latest.
- R6: sym_vld_o never pulses for a bit taken while the block is hunting.
- R7: While locked, a comma whose first bit is not the first bit of a symbol gives a one-cycle align_err_o pulse together with comma_o. The symbol boundary is left unchanged. A comma on the boundary gives no align_err_o.
- R8: When 4 consecutive emitted symbols each contain a misaligned comma, the block returns to hunting. That fourth symbol is still emitted, and locked_o falls in the same cycle. A symbol with no misaligned comma restarts this count.
- R9: rec_err_i high forces hunting on the next cycle. The bit offered in that cycle is discarded, and the comma window is emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | sample clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| bit_i | input | 1 | recovered serial bit |
| bit_vld_i | input | 1 | bit_i is valid this cycle |
| rec_err_i | input | 1 | error flag from bit recovery |
| comma_o | output | 1 | comma run detected (pulse) |
| locked_o | output | 1 | symbol boundary established |
| align_err_o | output | 1 | comma seen off the boundary (pulse) |
| sym_vld_o | output | 1 | sym_o holds a new symbol (pulse) |
| sym_o | output | 10 | aligned symbol, bit 0 first received |

## Verification
The assertions assume that a comma run appears in the stream only where a genuine alignment symbol starts. They also assume that recovery errors and valid strobes are synchronous to clk_i. The stimulus keeps to the first assumption in two ways. Random bits never repeat one value more than four times in a row, so no comma can form by chance. Each alignment symbol takes the polarity whose first bit differs from the bit sent just before it. Misaligned commas are then produced only on purpose, by slipping a few extra bits into the stream, so every align_err_o pulse the bench expects comes from a known offset.

// File: rtl/sync_pkg.sv
package sync_pkg;
  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_LOCKED = 1'b1
  } sync_state_e;
endpackage

// File: rtl/sync_shift.sv
module sync_shift #(
  parameter int SYM_W   = 10,
  parameter int COMMA_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             take_i,
  input  logic             bit_i,
  output logic [SYM_W-1:0] win_o,
  output logic             full_o
);
  localparam int FW = $clog2(COMMA_W + 1);

  logic [SYM_W-1:0] sr_q;
  logic [FW-1:0]    fill_q;

  // newest bit at the top, oldest falls out of bit 0
  assign win_o  = {bit_i, sr_q[SYM_W-1:1]};
  assign full_o = (fill_q >= FW'(COMMA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      fill_q <= '0;
    end else if (flush_i) begin
      sr_q   <= '0;
      fill_q <= '0;
    end else if (take_i) begin
      sr_q <= win_o;
      if (fill_q != FW'(COMMA_W)) fill_q <= fill_q + FW'(1);
    end
  end
endmodule

// File: rtl/sync_comma_det.sv
module sync_comma_det #(
  parameter int               SYM_W     = 10,
  parameter int               COMMA_W   = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input  logic             take_i,
  input  logic             full_i,
  input  logic [SYM_W-1:0] win_i,
  output logic             hit_o
);
  logic [COMMA_W-1:0] tail;
  logic [1:0]         match;

  assign tail = win_i[SYM_W-1 -: COMMA_W];

  // polarity 0: pattern as given, polarity 1: complement
  for (genvar p = 0; p < 2; p++) begin : g_pol
    localparam logic [COMMA_W-1:0] PAT = (p == 0) ? COMMA_PAT : ~COMMA_PAT;
    assign match[p] = (tail == PAT);
  end

  assign hit_o = take_i & full_i & (|match);
endmodule

// File: rtl/sync_fsm.sv
module sync_fsm
  import sync_pkg::*;
#(
  parameter int SYM_W     = 10,
  parameter int COMMA_W   = 7,
  parameter int ERR_LIMIT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             take_i,
  input  logic             hit_i,
  input  logic [SYM_W-1:0] win_i,
  output sync_state_e      state_o,
  output logic             comma_o,
  output logic             align_err_o,
  output logic             sym_vld_o,
  output logic [SYM_W-1:0] sym_o
);
  localparam int CW = $clog2(SYM_W);
  localparam int RW = (ERR_LIMIT > 1) ? $clog2(ERR_LIMIT) : 1;

  sync_state_e      state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [RW-1:0]    run_q, run_d;
  logic             bad_q, bad_d;
  logic             comma_d, aerr_d, vld_d;
  logic [SYM_W-1:0] sym_d;
  logic             mis, last, bad_sym;

  assign mis     = hit_i && (cnt_q != CW'(COMMA_W - 1));
  assign last    = (cnt_q == CW'(SYM_W - 1));
  assign bad_sym = bad_q | mis;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    run_d   = run_q;
    bad_d   = bad_q;
    comma_d = 1'b0;
    aerr_d  = 1'b0;
    vld_d   = 1'b0;
    sym_d   = sym_o;
    if (flush_i) begin
      state_d = ST_HUNT;
      cnt_d   = '0;
      run_d   = '0;
      bad_d   = 1'b0;
    end else if (take_i) begin
      comma_d = hit_i;
      if (state_q == ST_HUNT) begin
        if (hit_i) begin
          state_d = ST_LOCKED;
          cnt_d   = CW'(COMMA_W);
          run_d   = '0;
          bad_d   = 1'b0;
        end
      end else begin
        aerr_d = mis;
        if (last) begin
          cnt_d = '0;
          vld_d = 1'b1;
          sym_d = win_i;
          bad_d = 1'b0;
          if (bad_sym) begin
            if (run_q == RW'(ERR_LIMIT - 1)) begin
              state_d = ST_HUNT;
              run_d   = '0;
            end else begin
              run_d = run_q + RW'(1);
            end
          end else begin
            run_d = '0;
          end
        end else begin
          cnt_d = cnt_q + CW'(1);
          bad_d = bad_sym;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_HUNT;
      cnt_q       <= '0;
      run_q       <= '0;
      bad_q       <= 1'b0;
      comma_o     <= 1'b0;
      align_err_o <= 1'b0;
      sym_vld_o   <= 1'b0;
      sym_o       <= '0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      run_q       <= run_d;
      bad_q       <= bad_d;
      comma_o     <= comma_d;
      align_err_o <= aerr_d;
      sym_vld_o   <= vld_d;
      sym_o       <= sym_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/comma_sync.sv
module comma_sync
  import sync_pkg::*;
#(
  parameter int                 SYM_W     = 10,
  parameter int                 COMMA_W   = 7,
  parameter int                 ERR_LIMIT = 4,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             bit_vld_i,
  input  logic             rec_err_i,
  output logic             comma_o,
  output logic             locked_o,
  output logic             align_err_o,
  output logic             sym_vld_o,
  output logic [SYM_W-1:0] sym_o
);
  logic             take;
  logic [SYM_W-1:0] win;
  logic             full, hit;
  sync_state_e      state;

  assign take = bit_vld_i & ~rec_err_i;

  sync_shift #(.SYM_W(SYM_W), .COMMA_W(COMMA_W)) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(rec_err_i),
    .take_i (take),
    .bit_i  (bit_i),
    .win_o  (win),
    .full_o (full)
  );

  sync_comma_det #(.SYM_W(SYM_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)) i_det (
    .take_i(take),
    .full_i(full),
    .win_i (win),
    .hit_o (hit)
  );

  sync_fsm #(.SYM_W(SYM_W), .COMMA_W(COMMA_W), .ERR_LIMIT(ERR_LIMIT)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (rec_err_i),
    .take_i     (take),
    .hit_i      (hit),
    .win_i      (win),
    .state_o    (state),
    .comma_o    (comma_o),
    .align_err_o(align_err_o),
    .sym_vld_o  (sym_vld_o),
    .sym_o      (sym_o)
  );

  assign locked_o = (state == ST_LOCKED);
endmodule

// File: rtl/comma_sync_chk.sv
module comma_sync_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_vld_i,
  input logic rec_err_i,
  input logic comma_o,
  input logic locked_o,
  input logic align_err_o,
  input logic sym_vld_o
);
  AST_VLD_NEEDS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |-> $past(bit_vld_i && !rec_err_i)); // R2
  AST_COMMA_NEEDS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comma_o |-> $past(bit_vld_i && !rec_err_i)); // R3
  AST_LOCK_ON_COMMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> comma_o); // R4
  AST_NO_SYM_IN_HUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |-> $past(locked_o)); // R6
  AST_ERR_WITH_COMMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> (comma_o && $past(locked_o))); // R7
  AST_LOSS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> ($past(rec_err_i) || (sym_vld_o && align_err_o) || sym_vld_o)); // R8
  AST_REC_ERR_HUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_err_i |=> (!locked_o && !sym_vld_o && !comma_o)); // R9
endmodule

bind comma_sync comma_sync_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_vld_i  (bit_vld_i),
  .rec_err_i  (rec_err_i),
  .comma_o    (comma_o),
  .locked_o   (locked_o),
  .align_err_o(align_err_o),
  .sym_vld_o  (sym_vld_o)
);

// File: tb/test_comma_sync.sv
`timescale 1ns/1ps
module test_comma_sync;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_i = 1'b0, bit_vld_i = 1'b0, rec_err_i = 1'b0;
  logic       comma_o, locked_o, align_err_o, sym_vld_o;
  logic [9:0] sym_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  comma_sync i_comma_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
    .rec_err_i(rec_err_i), .comma_o(comma_o), .locked_o(locked_o),
    .align_err_o(align_err_o), .sym_vld_o(sym_vld_o), .sym_o(sym_o)
  );

  // reference model state
  logic [9:0] m_hist, m_sym;
  int         m_fill, m_cnt, m_run;
  logic       m_lock, m_bad, e_comma, e_aerr, e_vld;
  // stream tracker: no value repeats more than 4 times
  logic       last_b = 1'b0;
  int         run_len = 0;

  task automatic m_reset();
    m_hist = '0; m_sym = '0; m_fill = 0; m_cnt = 0; m_run = 0;
    m_lock = 0; m_bad = 0; e_comma = 0; e_aerr = 0; e_vld = 0;
  endtask

  task automatic m_step(input logic b, input logic v, input logic e);
    logic [9:0] win;
    logic hit, mis, bs;
    e_comma = 0; e_aerr = 0; e_vld = 0;
    if (e) begin
      m_lock = 0; m_cnt = 0; m_run = 0; m_bad = 0; m_fill = 0; m_hist = '0;
    end else if (v) begin
      win = {b, m_hist[9:1]};
      hit = (m_fill >= 6) && (win[9:3] == 7'b1111100 || win[9:3] == 7'b0000011);
      e_comma = hit;
      if (!m_lock) begin
        if (hit) begin m_lock = 1; m_cnt = 7; m_run = 0; m_bad = 0; end
      end else begin
        mis = hit && (m_cnt != 6);
        e_aerr = mis;
        bs = m_bad | mis;
        if (m_cnt == 9) begin
          m_cnt = 0; e_vld = 1; m_sym = win; m_bad = 0;
          if (bs) begin
            if (m_run == 3) begin m_lock = 0; m_run = 0; end
            else m_run++;
          end else m_run = 0;
        end else begin
          m_cnt++; m_bad = bs;
        end
      end
      m_hist = win;
      if (m_fill < 7) m_fill++;
    end
  endtask

  task automatic cmp(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic b, input logic v, input logic e);
    bit_i = b; bit_vld_i = v; rec_err_i = e;
    m_step(b, v, e);
    @(negedge clk_i);
    cmp("R3 comma_o", {9'b0, comma_o}, {9'b0, e_comma});
    cmp("R4 locked_o", {9'b0, locked_o}, {9'b0, m_lock});
    cmp("R7 align_err_o", {9'b0, align_err_o}, {9'b0, e_aerr});
    cmp("R6 sym_vld_o", {9'b0, sym_vld_o}, {9'b0, e_vld});
    if (e_vld) cmp("R5 sym_o", sym_o, m_sym);
    bit_vld_i = 0; rec_err_i = 0;
  endtask

  task automatic track(input logic b);
    if (b == last_b) run_len++; else begin run_len = 1; last_b = b; end
  endtask

  function automatic logic gen_bit();
    logic b = 1'($urandom);
    if (run_len >= 4 && b == last_b) b = ~b;
    return b;
  endfunction

  // gaps with bit_vld_i low carry random, ignored bit values (R2)
  task automatic send_bit(input logic b);
    while ($urandom % 4 == 0) step(1'($urandom), 1'b0, 1'b0);
    step(b, 1'b1, 1'b0);
    track(b);
  endtask

  task automatic send_data(input int n);
    for (int i = 0; i < n; i++) send_bit(gen_bit());
  endtask

  task automatic send_comma();
    logic [9:0] w;
    w = last_b ? 10'b1001111100 : 10'b0110000011;
    for (int i = 0; i < 10; i++) send_bit(w[i]);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    m_reset();
    #1;
    cmp("R1 reset comma_o", {9'b0, comma_o}, 10'd0);
    cmp("R1 reset locked_o", {9'b0, locked_o}, 10'd0);
    cmp("R1 reset align_err_o", {9'b0, align_err_o}, 10'd0);
    cmp("R1 reset sym_vld_o", {9'b0, sym_vld_o}, 10'd0);
    cmp("R1 reset sym_o", sym_o, 10'd0);
    @(negedge clk_i);
    rst_ni = 1;
    last_b = 0; run_len = 0;
  endtask

  initial begin
    void'($urandom(32'd7311));
    m_reset();
    do_reset();
    // R3: five ones after reset must not complete a comma with reset zeros
    for (int i = 0; i < 5; i++) begin step(1'b1, 1'b1, 1'b0); track(1'b1); end
    cmp("R3 no comma from reset fill", {9'b0, comma_o}, 10'd0);
    send_data(40);
    cmp("R6 still hunting", {9'b0, locked_o}, 10'd0);
    // R2: invalid bits that would form a comma are ignored
    for (int i = 0; i < 10; i++) step(1'(10'b1001111100 >> i), 1'b0, 1'b0);
    cmp("R2 ignored bits", {9'b0, locked_o}, 10'd0);
    send_comma();
    send_data(120);
    send_comma();
    send_data(50);
    cmp("R4 locked after comma", {9'b0, locked_o}, 10'd1);
    // R7/R8: slip three bits, misaligned commas until lock is lost
    send_data(3);
    for (int i = 0; i < 6; i++) send_comma();
    cmp("R8 relocked on new boundary", {9'b0, locked_o}, 10'd1);
    send_data(7);
    for (int i = 0; i < 8; i++) begin send_comma(); send_data(10); end
    // R9: recovery error drops lock
    step(1'b1, 1'b1, 1'b1);
    cmp("R9 hunt after rec_err", {9'b0, locked_o}, 10'd0);
    send_data(30);
    send_comma();
    send_data(40);
    for (int i = 0; i < 300; i++) begin
      case ($urandom % 8)
        0, 1:    send_comma();
        2:       send_data(1 + $urandom % 4);
        3:       if ($urandom % 4 == 0) step(1'($urandom), 1'b1, 1'b1);
        default: send_data(10);
      endcase
    end
    do_reset();
    send_data(20);
    send_comma();
    send_data(30);
    cmp("R4 locked after reset and comma", {9'b0, locked_o}, 10'd1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule